// File: doc/BRIEF.md
# Transfer-triggered functional clock freeze controller

This block sits beside a valid/ready link between two functional units and halts the whole functional domain each time a transfer completes on that link. The functional domain is modelled as a clock enable. The block derives this enable from a free-running debug clock through a fixed divider. In the same debug-clock edge where a transfer completes, the block latches the transfer's payload for a trace recorder. It also drops the functional enable, and the enable stays low until the recorder reports that the payload has been stored.

The recorder, the capture register and this controller all run on the debug clock, and that clock never stops. While the functional units are frozen the recorder can therefore spend any number of cycles storing a record. The result is a gap-free, in-order trace of every armed transfer. An arm input gates new triggers. A frozen flag and a wrapping freeze counter report the controller's status.

Top module: `trace_freeze_ctrl`

## Requirements
- R1: When `arm_i`, `mon_valid_i`, `mon_ready_i` and `func_ce_o` are all high at a debug-clock edge, then from the next cycle `frozen_o` and `cap_valid_o` are 1 and `cap_data_o` equals the `mon_data_i` value sampled at that edge.
- R2: While `frozen_o` is 1, `func_ce_o` is 0 in every cycle, so no functional transfer can complete.
- R3: While frozen, `rec_done_i` sampled high at an edge clears `frozen_o` and `cap_valid_o` in the next cycle. Without it the frozen state holds. `rec_done_i` has no effect when the controller is not frozen.
- R4: When not frozen, `func_ce_o` is 1 exactly in the debug cycles whose index k (the number of edges since reset release) satisfies k mod DIV = DIV-1. The divider keeps counting through a freeze.
- R5: `cap_data_o` stays unchanged while `cap_valid_o` is 1, until the release edge.
- R6: While `arm_i` is 0, no new freeze starts and `freeze_cnt_o` does not change. A freeze already in progress still waits for `rec_done_i`.
- R7: `freeze_cnt_o` increments by one, modulo 2^CNT_W, on each freeze, and is visible in the same cycle that `frozen_o` rises.
- R8: A handshake with `mon_valid_i` and `mon_ready_i` high in a cycle where `func_ce_o` is 0 is not a transfer and triggers nothing.
- R9: Every transfer completed while armed is presented to the recorder exactly once, in order, with no transfer lost when transfers come back to back.
- R10: During and right after reset, `frozen_o`, `cap_valid_o` and `freeze_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running debug clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Enables triggering on transfers |
| mon_valid_i | input | 1 | Monitored link valid |
| mon_ready_i | input | 1 | Monitored link ready |
| mon_data_i | input | DATA_W | Monitored link payload |
| rec_done_i | input | 1 | Recorder finished storing the capture |
| func_ce_o | output | 1 | Functional-domain clock enable |
| cap_valid_o | output | 1 | Captured payload waiting for the recorder |
| cap_data_o | output | DATA_W | Captured payload |
| frozen_o | output | 1 | Functional domain is halted |
| freeze_cnt_o | output | CNT_W | Number of freezes since reset, wrapping |

## Verification
A trigger sampled at an edge shows up on `frozen_o`, `cap_valid_o`, `cap_data_o` and `freeze_cnt_o` one debug cycle later. The bench reads them at the following falling edge. A release by `rec_done_i` also takes effect after one cycle. `func_ce_o` depends only on the current state and divider phase, so the bench predicts it for the current cycle from a count of edges since reset and checks it before the next edge. A bench recorder with random latency compares each capture against a queue of the transfers that the bench's own functional-unit model completed.

// File: rtl/trace_freeze_pkg.sv
package trace_freeze_pkg;
  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_FROZEN = 1'b1
  } frz_state_e;
endpackage

// File: rtl/tf_tick_gen.sv
module tf_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  // free running: phase is never disturbed by a freeze
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/tf_capture.sv
module tf_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clear_i) |=> ($stable(data_q) && valid_q)); // R5
endmodule

// File: rtl/tf_freeze_fsm.sv
module tf_freeze_fsm
  import trace_freeze_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             done_i,
  output logic             frozen_o,
  output logic [CNT_W-1:0] cnt_o
);
  frz_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (fire_i) state_d = ST_FROZEN;
      ST_FROZEN: if (done_i) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fire_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frozen_o = (state_q == ST_FROZEN);
  assign cnt_o    = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R7
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/trace_freeze_ctrl.sv
module trace_freeze_ctrl #(
  parameter int DIV    = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              mon_valid_i,
  input  logic              mon_ready_i,
  input  logic [DATA_W-1:0] mon_data_i,
  input  logic              rec_done_i,
  output logic              func_ce_o,
  output logic              cap_valid_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              frozen_o,
  output logic [CNT_W-1:0]  freeze_cnt_o
);
  logic tick, frozen, fire, release_cap;

  tf_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  // a transfer completes only on an enabled functional edge
  assign func_ce_o   = tick & ~frozen;
  assign fire        = arm_i & mon_valid_i & mon_ready_i & func_ce_o;
  assign release_cap = rec_done_i & frozen;

  tf_freeze_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .done_i  (rec_done_i),
    .frozen_o(frozen),
    .cnt_o   (freeze_cnt_o)
  );

  tf_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fire),
    .data_i (mon_data_i),
    .clear_i(release_cap),
    .valid_o(cap_valid_o),
    .data_o (cap_data_o)
  );

  assign frozen_o = frozen;

  AST_TRIG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && mon_valid_i && mon_ready_i && func_ce_o) |=>
      (frozen_o && cap_valid_o && cap_data_o == $past(mon_data_i))); // R1
  AST_STOP_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && mon_valid_i && mon_ready_i && func_ce_o) |=> !func_ce_o); // R2
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !rec_done_i) |=> (frozen_o && cap_valid_o)); // R3
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && rec_done_i) |=> (!frozen_o && !cap_valid_o)); // R3
  AST_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !frozen_o) |=> (!frozen_o && $stable(freeze_cnt_o))); // R6
  AST_NO_LATE_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!func_ce_o && !frozen_o) |=> !frozen_o); // R8

  generate
    if (DIV > 1) begin : g_spacing
      AST_CE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        func_ce_o |=> !func_ce_o); // R4
    end
  endgenerate
endmodule

// File: tb/trace_freeze_ctrl_tb_top.sv
module trace_freeze_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int DW         = 16;
  localparam int CW         = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          arm_i = 1'b0;
  logic          mon_valid_i = 1'b0;
  logic          mon_ready_i = 1'b0;
  logic [DW-1:0] mon_data_i = '0;
  logic          rec_done_i = 1'b0;
  logic          func_ce_o, cap_valid_o, frozen_o;
  logic [DW-1:0] cap_data_o;
  logic [CW-1:0] freeze_cnt_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trace_freeze_ctrl #(.DIV(DIV), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i),
    .mon_valid_i(mon_valid_i), .mon_ready_i(mon_ready_i), .mon_data_i(mon_data_i),
    .rec_done_i(rec_done_i), .func_ce_o(func_ce_o), .cap_valid_o(cap_valid_o),
    .cap_data_o(cap_data_o), .frozen_o(frozen_o), .freeze_cnt_o(freeze_cnt_o)
  );

  int            cyc = 0;
  bit            exp_frozen = 0;
  int            exp_cnt = 0;
  logic [DW-1:0] exp_data = '0;
  logic [DW-1:0] seq = '0;
  logic [DW-1:0] pend_q[$];
  bit            pending = 0;
  int            delay = 0;
  bit            stream = 0;
  int            late_hs = 0;

  function automatic bit tick_f(int k);
    return (k % DIV) == DIV - 1;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit ce_e, hs, fire_e, done_e;
    ce_e = tick_f(cyc) && !exp_frozen;
    chk(func_ce_o == ce_e, exp_frozen ? "R2" : "R4", func_ce_o, ce_e);
    rec_done_i = 1'b0;
    if (cap_valid_o && !pending) begin
      logic [DW-1:0] want;
      want = (pend_q.size() > 0) ? pend_q.pop_front() : ~cap_data_o;
      chk(cap_data_o == want, "R9", cap_data_o, want);
      pending = 1;
      delay = $urandom_range(0, 3);
    end
    if (pending) begin
      if (delay == 0) begin rec_done_i = 1'b1; pending = 0; end
      else delay--;
    end
    // stray done pulse while running must be ignored
    if (!exp_frozen && $urandom_range(0, 15) == 0) rec_done_i = 1'b1;
    done_e = rec_done_i;
    hs = mon_valid_i && mon_ready_i;
    fire_e = arm_i && hs && ce_e;
    if (hs && !ce_e && !exp_frozen) late_hs++;
    if (arm_i && hs && ce_e) pend_q.push_back(mon_data_i);
    @(posedge clk_i);
    cyc++;
    @(negedge clk_i);
    if (fire_e) begin
      exp_frozen = 1; exp_cnt++; exp_data = mon_data_i;
    end else if (exp_frozen && done_e) exp_frozen = 0;
    chk(frozen_o == exp_frozen, fire_e ? "R1" : (hs && !ce_e) ? "R8" : "R3",
        frozen_o, exp_frozen);
    chk(cap_valid_o == exp_frozen, "R3", cap_valid_o, exp_frozen);
    chk(freeze_cnt_o == CW'(exp_cnt), arm_i ? "R7" : "R6", freeze_cnt_o, CW'(exp_cnt));
    if (exp_frozen) chk(cap_data_o == exp_data, fire_e ? "R1" : "R5", cap_data_o, exp_data);
    if (ce_e) begin
      if (hs) seq++;
      if (hs || !mon_valid_i) mon_valid_i = stream ? 1'b1 : 1'($urandom_range(0, 1));
      mon_data_i = seq;
      mon_ready_i = stream ? 1'b1 : ($urandom_range(0, 3) != 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt_before;
    repeat (3) @(negedge clk_i);
    chk(frozen_o == 0 && cap_valid_o == 0, "R10", {frozen_o, cap_valid_o}, 0);
    chk(freeze_cnt_o == 0, "R10", freeze_cnt_o, 0);
    rst_ni = 1'b1;
    chk(frozen_o == 0 && freeze_cnt_o == 0, "R10", freeze_cnt_o, 0);
    // stream phase: back-to-back transfers, each must still be recorded
    arm_i = 1'b1; stream = 1; mon_valid_i = 1'b1; mon_ready_i = 1'b1;
    repeat (120) step();
    chk(exp_cnt > 10, "R9", exp_cnt, 11);
    stream = 0;
    repeat (2000) step();
    // disarmed phase
    while (exp_frozen || pending) step();
    arm_i = 1'b0;
    cnt_before = exp_cnt;
    repeat (300) step();
    chk(freeze_cnt_o == CW'(cnt_before), "R6", freeze_cnt_o, CW'(cnt_before));
    chk(late_hs > 0, "R8", late_hs, 1);
    arm_i = 1'b1;
    repeat (2000) step();
    // drain
    arm_i = 1'b0; mon_valid_i = 1'b0;
    repeat (40) step();
    chk(pend_q.size() == 0, "R9", pend_q.size(), 0);
    chk(!frozen_o, "R3", frozen_o, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule